// File: doc/BRIEF.md
# Pointer-Indexed Timekeeping Register Window

This block is the bus-facing access window of a real-time clock. Software sees three locations: a control word and two 16-bit value windows, one onto the time fields and one onto the alarm fields. Each value window shows one pair of byte-wide fields at a time. Its high byte and low byte carry the two fields of that pair. A 2-bit pointer picks the pair, and each window has its own pointer. Software loads both pointers through the control word. It can then walk through all field pairs with consecutive accesses, because the pointer steps down after every read and after every write that touches the high byte. The timekeeping counters behind the window are modelled as plain storage bytes. The counters themselves, the alarm comparison and the unlock sequence are outside this block.

Each pointer is a small state machine with four named states. MINSEC is code 00 (minutes and seconds). WKDHR is code 01 (weekday and hours). MONDAY is code 10 (month and day). TOP is code 11 (year only). The transitions are STEP_DOWN, which moves TOP to MONDAY, MONDAY to WKDHR and WKDHR to MINSEC. HOLD_AT_FLOOR keeps MINSEC when a step is requested there. LOAD jumps from any state to the value written through the control word. When a load and a step fall in the same cycle, the load wins. No stimulus makes the pointer wrap from MINSEC to TOP. A read returns data in the same cycle as `rd_en`, using the pointer value from before that cycle's step. A write lands in the pair the pointer selects before it steps.

Top module: `rtc_reg_window`

## Requirements
- R1: After reset both pointers are 00 and every field byte is zero, so the control word and both windows read 0x0000.
- R2: Location select `bus_sel` uses 00 for the control word, 01 for the time window, 10 for the alarm window and 11 for an unused location that reads 0x0000 and has no effect. In the time window, pointer 00 shows minutes[15:8] and seconds[7:0]. Pointer 01 shows weekday[15:8] and hours[7:0]. Pointer 10 shows month[15:8] and day[7:0]. Pointer 11 shows year[7:0].
- R3: A window write with `byte_en[1]` set steps that window's pointer down by one after the access. At 00 the pointer stays at 00 and never wraps to 11.
- R4: Any read of a window steps that window's pointer down once per read cycle, whatever `byte_en` is, with the same saturation at 00. The other window's pointer is unchanged.
- R5: A window write with only `byte_en[0]` set writes the low byte and leaves the pointer unchanged.
- R6: Time field bytes change only on writes made while `tmr_wen` is 1. With `tmr_wen` at 0 such writes are ignored, but the pointer still steps as in R3.
- R7: The alarm window maps alarm minutes/seconds to pointer 00, alarm weekday/hours to 01 and alarm month/day to 10. Pointer 11 reads 0x0000 and ignores writes. Alarm writes do not depend on `tmr_wen`.
- R8: A control write with `byte_en[0]` set loads the time pointer from `wr_data[1:0]` and the alarm pointer from `wr_data[3:2]`. A control read returns the alarm pointer in [3:2], the time pointer in [1:0] and zero elsewhere, and does not move either pointer.
- R9: The high byte at time pointer 11 reads zero and ignores writes, while the year byte in the same access is written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 2 | Location select: 00 control, 01 time window, 10 alarm window, 11 unused |
| wr_en | input | 1 | Write strobe for the selected location |
| byte_en | input | 2 | Byte enables for writes: [1] high byte, [0] low byte |
| wr_data | input | 2*BYTE_W | Write data |
| rd_en | input | 1 | Read strobe for the selected location |
| rd_data | output | 2*BYTE_W | Read data, valid in the cycle `rd_en` is high |
| tmr_wen | input | 1 | Enables writes to the time field bytes |

## Verification
The bench builds the block with its default byte width of 8, so each window is a 16-bit word and the two pointers sit in the low four bits of the control word. At that width the bench can load both pointers to 11 and walk each window down through all four states with writes and then with reads. It drives repeated accesses at 00 to show the pointer holds there, and it places control writes between window accesses to expose the pointer of the window that was not touched. A reference model in the bench applies the stepping, gating and unimplemented-byte rules to every access. A scoreboard compares each read against the model.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
    typedef enum logic [1:0] {
        PAIR_MINSEC = 2'b00,
        PAIR_WKDHR  = 2'b01,
        PAIR_MONDAY = 2'b10,
        PAIR_TOP    = 2'b11
    } pair_e;

    typedef enum logic [1:0] {
        LOC_CTRL  = 2'b00,
        LOC_TIME  = 2'b01,
        LOC_ALARM = 2'b10,
        LOC_NONE  = 2'b11
    } loc_e;

    localparam int PAIRS = 4;
    localparam int SLOTS = 2 * PAIRS;
endpackage

// File: rtl/rtw_ptr_fsm.sv
module rtw_ptr_fsm
    import rtw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  pair_e load_val,
    input  logic  step,
    output pair_e cur
);
    pair_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= PAIR_MINSEC;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        if (load) begin
            nxt = load_val;
        end else if (step) begin
            unique case (cur_q)
                PAIR_TOP:    nxt = PAIR_MONDAY;
                PAIR_MONDAY: nxt = PAIR_WKDHR;
                PAIR_WKDHR:  nxt = PAIR_MINSEC;
                PAIR_MINSEC: nxt = PAIR_MINSEC;
            endcase
        end
    end

    always_comb cur = cur_q;

    logic [1:0] cur_bits, load_bits;
    assign cur_bits  = cur_q;
    assign load_bits = load_val;

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur_bits != 2'b00) |=> cur_bits == $past(cur_bits) - 2'd1);
    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur_bits == 2'b00) |=> cur_bits == 2'b00);
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_bits == $past(load_bits));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_bits));
endmodule

// File: rtl/rtw_field_bank.sv
module rtw_field_bank
    import rtw_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter bit HAS_YEAR = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pair_e               pair,
    input  logic                wr,
    input  logic [1:0]          be,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic [2*BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0]        slot [SLOTS];
    logic [SLOTS*BYTE_W-1:0]  flat;
    logic [1:0]               pair_idx;

    assign pair_idx = pair;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam bit IMPL = (i != SLOTS - 1) && ((i != SLOTS - 2) || HAS_YEAR);
        if (IMPL) begin : g_reg
            logic [BYTE_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val_q <= '0;
                else if (wr && pair_idx == 2'(i / 2) && be[i % 2])
                    val_q <= wdata[(i % 2) * BYTE_W +: BYTE_W];
            end
            assign slot[i] = val_q;
        end else begin : g_nil
            assign slot[i] = '0;
        end
        assign flat[i*BYTE_W +: BYTE_W] = slot[i];
    end

    assign rdata = {slot[{pair_idx, 1'b1}], slot[{pair_idx, 1'b0}]};

    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(flat));
endmodule

// File: rtl/rtc_reg_window.sv
module rtc_reg_window
    import rtw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_sel,
    input  logic                wr_en,
    input  logic [1:0]          byte_en,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic                rd_en,
    output logic [2*BYTE_W-1:0] rd_data,
    input  logic                tmr_wen
);
    localparam int WORD_W = 2 * BYTE_W;

    loc_e  loc;
    pair_e tptr, aptr;
    logic  ptr_load, t_step, a_step, t_wr, a_wr;
    logic [WORD_W-1:0] t_rdata, a_rdata;

    assign loc      = loc_e'(bus_sel);
    assign ptr_load = (loc == LOC_CTRL) && wr_en && byte_en[0];
    assign t_step   = (loc == LOC_TIME)  && (rd_en || (wr_en && byte_en[1]));
    assign a_step   = (loc == LOC_ALARM) && (rd_en || (wr_en && byte_en[1]));
    assign t_wr     = (loc == LOC_TIME)  && wr_en && tmr_wen;
    assign a_wr     = (loc == LOC_ALARM) && wr_en;

    rtw_ptr_fsm u_tptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val(pair_e'(wr_data[1:0])), .step(t_step), .cur(tptr)
    );

    rtw_ptr_fsm u_aptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val(pair_e'(wr_data[3:2])), .step(a_step), .cur(aptr)
    );

    rtw_field_bank #(.BYTE_W(BYTE_W), .HAS_YEAR(1'b1)) u_time (
        .clk(clk), .rst_n(rst_n), .pair(tptr), .wr(t_wr),
        .be(byte_en), .wdata(wr_data), .rdata(t_rdata)
    );

    rtw_field_bank #(.BYTE_W(BYTE_W), .HAS_YEAR(1'b0)) u_alarm (
        .clk(clk), .rst_n(rst_n), .pair(aptr), .wr(a_wr),
        .be(byte_en), .wdata(wr_data), .rdata(a_rdata)
    );

    always_comb begin
        rd_data = '0;
        unique case (loc)
            LOC_CTRL:  rd_data = {{(WORD_W-4){1'b0}}, aptr, tptr};
            LOC_TIME:  rd_data = t_rdata;
            LOC_ALARM: rd_data = a_rdata;
            LOC_NONE:  rd_data = '0;
        endcase
    end

    p_other_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loc == LOC_TIME && !ptr_load) |=> $stable(aptr));
endmodule

// File: tb/sim_rtc_reg_window.sv
module sim_rtc_reg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_sel = 2'b11;
    logic        wr_en = 1'b0;
    logic [1:0]  byte_en = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        tmr_wen = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    logic [7:0] tm [8];
    logic [7:0] am [8];
    int tp = 0;
    int ap = 0;

    always #5 clk = ~clk;

    rtc_reg_window u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .wr_en(wr_en),
        .byte_en(byte_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .tmr_wen(tmr_wen)
    );

    // monitor: pops expected words as reads happen
    always begin
        @(negedge clk);
        #2;
        if (rd_en) begin
            logic [15:0] e;
            string t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL %s: read with empty scoreboard act=%h exp=none", "R2", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    bad++;
                    $display("FAIL %s: act=%h exp=%h", t, rd_data, e);
                end
            end
        end
    end

    // driver plus reference model
    task automatic op(input logic [1:0] sel, input logic w, input logic [1:0] be,
                      input logic [15:0] d, input logic r, input string tag);
        logic [15:0] e;
        e = 16'h0;
        if (sel == 2'd0) e = {12'h0, 2'(ap), 2'(tp)};
        else if (sel == 2'd1) e = {tm[tp*2+1], tm[tp*2]};
        else if (sel == 2'd2) e = {am[ap*2+1], am[ap*2]};
        if (r) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        bus_sel = sel; wr_en = w; byte_en = be; wr_data = d; rd_en = r;
        if (w && sel == 2'd0 && be[0]) begin
            tp = int'(d[1:0]);
            ap = int'(d[3:2]);
        end
        if (w && sel == 2'd1 && tmr_wen) begin
            if (be[0]) tm[tp*2] = d[7:0];
            if (be[1] && tp != 3) tm[tp*2+1] = d[15:8];
        end
        if (w && sel == 2'd2 && ap != 3) begin
            if (be[0]) am[ap*2] = d[7:0];
            if (be[1]) am[ap*2+1] = d[15:8];
        end
        if (sel == 2'd1 && (r || (w && be[1])) && tp > 0) tp--;
        if (sel == 2'd2 && (r || (w && be[1])) && ap > 0) ap--;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; bus_sel = 2'b11;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin tm[i] = 8'h0; am[i] = 8'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        op(2'd0, 0, 2'b00, 16'h0, 1, "R1");
        op(2'd1, 0, 2'b11, 16'h0, 1, "R1");
        op(2'd2, 0, 2'b11, 16'h0, 1, "R1");
        // R8 load time pointer to 11, alarm to 11
        op(2'd0, 1, 2'b01, 16'h000F, 0, "R8");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R8");
        // R5 low-only write keeps pointer at 11
        tmr_wen = 1'b1;
        op(2'd1, 1, 2'b01, 16'h0020, 0, "R5");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R5");
        // R3 / R9 walk down with high-byte writes
        op(2'd1, 1, 2'b11, 16'hAB21, 0, "R9");
        op(2'd1, 1, 2'b11, 16'h0C15, 0, "R3");
        op(2'd1, 1, 2'b11, 16'h0309, 0, "R3");
        op(2'd1, 1, 2'b11, 16'h3B2A, 0, "R3");
        op(2'd1, 1, 2'b11, 16'h1E11, 0, "R3");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R3");
        // R2 / R4 walk down with reads, alarm pointer untouched
        op(2'd0, 1, 2'b01, 16'h000F, 0, "R8");
        op(2'd1, 0, 2'b00, 16'h0, 1, "R9");
        op(2'd1, 0, 2'b01, 16'h0, 1, "R2");
        op(2'd1, 0, 2'b10, 16'h0, 1, "R2");
        op(2'd1, 0, 2'b11, 16'h0, 1, "R2");
        op(2'd1, 0, 2'b11, 16'h0, 1, "R4");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R4");
        // R6 locked writes ignored, pointer still steps
        tmr_wen = 1'b0;
        op(2'd1, 1, 2'b11, 16'h5555, 0, "R6");
        op(2'd1, 0, 2'b00, 16'h0, 1, "R6");
        op(2'd0, 1, 2'b01, 16'h000E, 0, "R6");
        op(2'd1, 1, 2'b10, 16'h7700, 0, "R6");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R6");
        op(2'd1, 0, 2'b00, 16'h0, 1, "R6");
        // R7 alarm window, ungated, code 11 unimplemented
        op(2'd0, 1, 2'b01, 16'h000C, 0, "R8");
        op(2'd2, 1, 2'b11, 16'hFFFF, 0, "R7");
        op(2'd2, 1, 2'b11, 16'h0A0B, 0, "R7");
        op(2'd2, 1, 2'b11, 16'h0506, 0, "R7");
        op(2'd2, 1, 2'b11, 16'h1E2D, 0, "R7");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R7");
        op(2'd0, 1, 2'b01, 16'h000C, 0, "R8");
        op(2'd2, 0, 2'b00, 16'h0, 1, "R7");
        op(2'd2, 0, 2'b00, 16'h0, 1, "R7");
        op(2'd2, 0, 2'b00, 16'h0, 1, "R7");
        op(2'd2, 0, 2'b00, 16'h0, 1, "R4");
        op(2'd2, 0, 2'b00, 16'h0, 1, "R4");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R4");
        // R2 unused location
        op(2'd3, 1, 2'b11, 16'h000F, 1, "R2");
        op(2'd0, 0, 2'b00, 16'h0, 1, "R2");
        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R2: unconsumed reads act=%0d exp=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1: watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule